// File: doc/BRIEF.md
# ATAPI PIO Packet Read Sequencer

This block is the device side of a packet-command disk interface running in programmed I/O mode. The host programs a transfer size cap through two task-file byte registers, then issues the packet command. The device raises DRQ and takes in a 12-byte command packet as six 16-bit writes to the data register. A READ(10) packet names a starting block and a block count. The device then streams the requested 2048-byte blocks from a simple media port.

The data phase is split into bursts. Each burst is no larger than the host's cap with bit 0 cleared, and the final burst carries whatever is left. Before each burst the device raises its interrupt and shows DRQ. While the burst is open, the cap registers read back that burst's byte count. Between phases the device shows BSY for a short programmable interval. When the last word has been read, a final interrupt announces completion. A zero cap, a command other than the packet command, or a packet opcode other than READ(10) ends the command with an abort error.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status register (offset 7) reads 0x40, the error register (offset 1) reads 0x00, the cap registers read 0x00 and `intrq` is low.
- R2: Status bits are BSY 0x80, DRDY 0x40, DF 0x20, DRQ 0x08 and ERR 0x01. DRDY is always set, DF is always clear, and BSY and DRQ are never set together.
- R3: While idle, writes to offset 4 and offset 5 set the low and high bytes of the 16-bit byte cap, and outside a burst these offsets read the cap back.
- R4: Writing 0xA0 to offset 7 while idle with an even-rounded cap above zero clears ERR and abort and shows status 0x48. The next six writes to offset 0 are packet words, where word i holds packet byte 2i in bits 7:0 and byte 2i+1 in bits 15:8.
- R5: A packet with byte 0 equal to 0x28 reads blocks starting at the big-endian LBA in bytes 2..5, for the big-endian count in bytes 7..8. Successive reads of offset 0 return media word k of block LBA+n in stream order, with k cycling through 0..1023.
- R6: Each burst is min(remaining bytes, cap with bit 0 cleared) bytes long. During a burst, offsets 4 and 5 read that burst's byte count (low and high bytes).
- R7: Before each burst `intrq` rises and status reads 0x48.
- R8: After the last word of the last burst, `intrq` rises and status reads 0x40.
- R9: A status read clears `intrq` on the following cycle.
- R10: Status reads 0xC0 for BUSY_CYCLES cycles after the sixth packet word, and again between successive bursts.
- R11: A packet command with a cap below 2, or any other command code written while idle, sets `intrq`, status 0x41 and error register 0x04 (abort) at once, with no DRQ.
- R12: A packet opcode other than 0x28 gives status 0x41, error 0x04 and an interrupt at the end of the BSY interval.
- R13: A READ(10) with a block count of zero completes at the end of the BSY interval with an interrupt and status 0x40, and no data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tf_wr | input | 1 | Task-file write strobe, one cycle per access |
| tf_rd | input | 1 | Task-file read strobe; a read's side effects apply at the clock edge |
| tf_addr | input | 3 | Task-file register offset |
| tf_wdata | input | 16 | Write data; 8-bit registers use bits 7:0 |
| tf_rdata | output | 16 | Read data for the current offset (combinational) |
| intrq | output | 1 | Interrupt request to the host |
| med_lba | output | 32 | Block address presented to the media |
| med_word | output | 10 | Word index within that block |
| med_data | input | 16 | Media word for med_lba / med_word |

## Verification
The bench targets an odd cap such as 1001. A design that fails to round it down would make 1001-byte bursts and break the word count. A transfer whose size is an exact multiple of the cap is also run, where an off-by-one on the remaining count would add an empty burst or miss the completion. A six-block stream starting at a multi-byte LBA catches byte swaps in packet decoding and a missing block increment at each 1024-word wrap. The abort paths (zero cap, cap of one, a foreign command and a bad opcode) would otherwise leave DRQ set or lose the abort bit, and status is compared against a reference model on every cycle so that a shortened BSY gap shows up.

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq #(
  parameter int BLOCK_BYTES = 2048,
  parameter int BUSY_CYCLES = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tf_wr,
  input  logic                                tf_rd,
  input  logic [2:0]                          tf_addr,
  input  logic [15:0]                         tf_wdata,
  output logic [15:0]                         tf_rdata,
  output logic                                intrq,
  output logic [31:0]                         med_lba,
  output logic [$clog2(BLOCK_BYTES/2)-1:0]    med_word,
  input  logic [15:0]                         med_data
);
  localparam int WPB   = BLOCK_BYTES / 2;
  localparam int WW    = $clog2(WPB);
  localparam int REM_W = 16 + WW + 1;
  localparam int GW    = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_PKT, S_BUSY, S_XFER} st_t;

  st_t               st;
  logic [15:0]       bcl;
  logic [7:0]        dev;
  logic              abrt, errf, irq, first;
  logic [15:0]       pkt_w [6];
  logic [2:0]        pcnt;
  logic [GW-1:0]     gap;
  logic [31:0]       lba;
  logic [WW-1:0]     widx;
  logic [REM_W-1:0]  rem;
  logic [14:0]       burst;
  logic [15:0]       bbytes;

  wire wr_cmd  = tf_wr && tf_addr == 3'd7;
  wire wr_dat  = tf_wr && tf_addr == 3'd0;
  wire rd_stat = tf_rd && tf_addr == 3'd7;
  wire rd_dat  = tf_rd && tf_addr == 3'd0 && st == S_XFER;

  wire [14:0] lim_w  = bcl[15:1];
  wire [7:0]  opcode = pkt_w[0][7:0];
  wire [31:0] pk_lba = {pkt_w[1][7:0], pkt_w[1][15:8], pkt_w[2][7:0], pkt_w[2][15:8]};
  wire [15:0] pk_cnt = {pkt_w[3][15:8], pkt_w[4][7:0]};

  wire [REM_W-1:0] tot  = REM_W'(pk_cnt) * REM_W'(WPB);
  wire [REM_W-1:0] src  = first ? tot : rem;
  wire [14:0] burst_nx  = (src < REM_W'(lim_w)) ? src[14:0] : lim_w;

  wire       drq    = st == S_PKT || st == S_XFER;
  wire [7:0] status = {st == S_BUSY, 1'b1, 1'b0, 1'b0, drq, 2'b00, errf};

  assign intrq    = irq;
  assign med_lba  = lba;
  assign med_word = widx;

  always_comb begin
    case (tf_addr)
      3'd0:    tf_rdata = (st == S_XFER) ? med_data : 16'h0;
      3'd1:    tf_rdata = {13'h0, abrt, 2'b00};
      3'd4:    tf_rdata = {8'h0, (st == S_XFER) ? bbytes[7:0] : bcl[7:0]};
      3'd5:    tf_rdata = {8'h0, (st == S_XFER) ? bbytes[15:8] : bcl[15:8]};
      3'd6:    tf_rdata = {8'h0, dev};
      3'd7:    tf_rdata = {8'h0, status};
      default: tf_rdata = 16'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bcl <= '0;
      dev <= '0;
      abrt <= 1'b0;
      errf <= 1'b0;
      irq <= 1'b0;
      first <= 1'b0;
      for (int i = 0; i < 6; i++) pkt_w[i] <= '0;
      pcnt <= '0;
      gap <= '0;
      lba <= '0;
      widx <= '0;
      rem <= '0;
      burst <= '0;
      bbytes <= '0;
    end else begin
      if (rd_stat) irq <= 1'b0;
      case (st)
        S_IDLE: begin
          if (tf_wr && tf_addr == 3'd4) bcl[7:0]  <= tf_wdata[7:0];
          if (tf_wr && tf_addr == 3'd5) bcl[15:8] <= tf_wdata[7:0];
          if (tf_wr && tf_addr == 3'd6) dev       <= tf_wdata[7:0];
          if (wr_cmd) begin
            if (tf_wdata[7:0] == 8'hA0 && lim_w != '0) begin
              st <= S_PKT;
              pcnt <= '0;
              errf <= 1'b0;
              abrt <= 1'b0;
              irq <= 1'b0;
            end else begin
              errf <= 1'b1;
              abrt <= 1'b1;
              irq <= 1'b1;
            end
          end
        end
        S_PKT: begin
          if (wr_dat) begin
            pkt_w[pcnt] <= tf_wdata;
            pcnt <= pcnt + 3'd1;
            if (pcnt == 3'd5) begin
              st <= S_BUSY;
              gap <= GW'(BUSY_CYCLES - 1);
              first <= 1'b1;
            end
          end
        end
        S_BUSY: begin
          if (gap != '0) begin
            gap <= gap - 1'b1;
          end else if (first && opcode != 8'h28) begin
            first <= 1'b0;
            errf <= 1'b1;
            abrt <= 1'b1;
            irq <= 1'b1;
            st <= S_IDLE;
          end else if (first && pk_cnt == '0) begin
            first <= 1'b0;
            irq <= 1'b1;
            st <= S_IDLE;
          end else begin
            first <= 1'b0;
            rem <= src;
            burst <= burst_nx;
            bbytes <= {burst_nx, 1'b0};
            if (first) begin
              lba <= pk_lba;
              widx <= '0;
            end
            irq <= 1'b1;
            st <= S_XFER;
          end
        end
        S_XFER: begin
          if (rd_dat) begin
            if (widx == WW'(WPB - 1)) begin
              widx <= '0;
              lba <= lba + 32'd1;
            end else begin
              widx <= widx + 1'b1;
            end
            rem <= rem - 1'b1;
            burst <= burst - 1'b1;
            if (burst == 15'd1) begin
              if (rem == REM_W'(1)) begin
                irq <= 1'b1;
                st <= S_IDLE;
              end else begin
                gap <= GW'(BUSY_CYCLES - 1);
                st <= S_BUSY;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_no_bsy_drq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tf_rd && tf_addr == 3'd7 && tf_rdata[7] && tf_rdata[3]));

  p_bsy_before_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_XFER |-> $past(st) != S_PKT);

  p_burst_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_XFER |-> (bbytes <= {bcl[15:1], 1'b0}) && burst != '0);

  p_rem_covers_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_XFER |-> rem >= REM_W'(burst));

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !tf_wr && st != S_BUSY) |=> !intrq);

  p_err_only_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    errf |-> st == S_IDLE);
endmodule

// File: tb/atapi_pio_seq_tb.sv
module atapi_pio_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 2;
  localparam int WPB        = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tf_wr = 1'b0, tf_rd = 1'b0;
  logic [2:0]  tf_addr = 3'd7;
  logic [15:0] tf_wdata = '0;
  logic [15:0] tf_rdata;
  logic        intrq;
  logic [31:0] med_lba;
  logic [9:0]  med_word;
  logic [15:0] med_data;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mfn(input logic [31:0] l, input int w);
    return (l[15:0] * 16'd257) ^ (16'(w) * 16'd499) ^ 16'h5A5A;
  endfunction

  assign med_data = mfn(med_lba, int'(med_word));

  atapi_pio_seq #(.BLOCK_BYTES(2048), .BUSY_CYCLES(BUSY_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .tf_wr(tf_wr), .tf_rd(tf_rd), .tf_addr(tf_addr),
    .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .intrq(intrq),
    .med_lba(med_lba), .med_word(med_word), .med_data(med_data));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model: 0 idle, 1 packet, 2 busy, 3 data
  int m_st = 0, m_bcl = 0, m_dev = 0, m_abrt = 0, m_err = 0, m_irq = 0;
  int m_pc = 0, m_gap = 0, m_first = 0, m_widx = 0, m_rem = 0, m_bw = 0, m_bb = 0;
  int m_pk [6];
  logic [31:0] m_lba = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_bcl = 0; m_dev = 0; m_abrt = 0; m_err = 0; m_irq = 0;
      m_pc = 0; m_gap = 0; m_first = 0; m_widx = 0; m_rem = 0; m_bw = 0; m_bb = 0;
      m_lba = '0;
      for (int i = 0; i < 6; i++) m_pk[i] = 0;
    end else begin
      int lim, src, b, op, cnt;
      lim = m_bcl / 2;
      op  = m_pk[0] & 255;
      cnt = ((m_pk[3] >> 8) << 8) | (m_pk[4] & 255);
      if (tf_rd && tf_addr == 3'd7) m_irq = 0;
      case (m_st)
        0: begin
          if (tf_wr && tf_addr == 3'd4) m_bcl = (m_bcl & 'hFF00) | int'(tf_wdata[7:0]);
          if (tf_wr && tf_addr == 3'd5) m_bcl = (m_bcl & 'h00FF) | (int'(tf_wdata[7:0]) << 8);
          if (tf_wr && tf_addr == 3'd6) m_dev = int'(tf_wdata[7:0]);
          if (tf_wr && tf_addr == 3'd7) begin
            if (tf_wdata[7:0] == 8'hA0 && lim != 0) begin
              m_st = 1; m_pc = 0; m_err = 0; m_abrt = 0; m_irq = 0;
            end else begin
              m_err = 1; m_abrt = 1; m_irq = 1;
            end
          end
        end
        1: if (tf_wr && tf_addr == 3'd0) begin
          m_pk[m_pc] = int'(tf_wdata);
          if (m_pc == 5) begin m_st = 2; m_gap = BUSY_CYC - 1; m_first = 1; end
          m_pc++;
        end
        2: begin
          if (m_gap > 0) m_gap--;
          else if (m_first != 0 && op != 'h28) begin
            m_first = 0; m_err = 1; m_abrt = 1; m_irq = 1; m_st = 0;
          end else if (m_first != 0 && cnt == 0) begin
            m_first = 0; m_irq = 1; m_st = 0;
          end else begin
            src = (m_first != 0) ? cnt * WPB : m_rem;
            b = (src < lim) ? src : lim;
            if (m_first != 0) begin
              m_lba = {m_pk[1][7:0], m_pk[1][15:8], m_pk[2][7:0], m_pk[2][15:8]};
              m_widx = 0;
            end
            m_first = 0; m_rem = src; m_bw = b; m_bb = 2 * b; m_irq = 1; m_st = 3;
          end
        end
        default: if (tf_rd && tf_addr == 3'd0) begin
          if (m_widx == WPB - 1) begin m_widx = 0; m_lba = m_lba + 1; end
          else m_widx++;
          if (m_bw == 1) begin
            if (m_rem == 1) begin m_st = 0; m_irq = 1; end
            else begin m_st = 2; m_gap = BUSY_CYC - 1; end
          end
          m_rem--; m_bw--;
        end
      endcase
    end
  end

  function automatic int m_rdval(input int a);
    case (a)
      0: return (m_st == 3) ? int'(mfn(m_lba, m_widx)) : 0;
      1: return m_abrt << 2;
      4: return ((m_st == 3) ? m_bb : m_bcl) & 255;
      5: return (((m_st == 3) ? m_bb : m_bcl) >> 8) & 255;
      6: return m_dev;
      7: return ((m_st == 2) ? 'h80 : 0) | 'h40 | ((m_st == 1 || m_st == 3) ? 8 : 0) | m_err;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(tf_addr == 3'd7 ? "R2 status vs model" : (tf_addr == 3'd0 ? "R5 data vs model" : "R6 reg vs model"),
          int'(tf_rdata), m_rdval(int'(tf_addr)));
      chk("R7 intrq vs model", int'(intrq), m_irq);
      if (tf_addr == 3'd7) chk("R2 no BSY with DRQ, DF clear", int'((tf_rdata[7] & tf_rdata[3]) | tf_rdata[5]), 0);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    tf_addr = a; tf_wdata = d; tf_wr = 1'b1; tf_rd = 1'b0;
    @(posedge clk); #1;
    tf_wr = 1'b0; tf_addr = 3'd7;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    tf_addr = a; tf_rd = 1'b1; tf_wr = 1'b0;
    #2 d = int'(tf_rdata);
    @(posedge clk); #1;
    tf_rd = 1'b0; tf_addr = 3'd7;
  endtask

  task automatic wait_irq(input string tag);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #3;
      if (intrq) break;
    end
    chk(tag, int'(intrq), 1);
  endtask

  task automatic packet(input int lim, input int op, input logic [31:0] lba, input int cnt);
    int s, lo, hi, total, b, k;
    wr(3'd4, 16'(lim & 255));
    wr(3'd5, 16'((lim >> 8) & 255));
    wr(3'd7, 16'h00A0);
    rd(3'd7, s); chk("R4 status after packet command", s, 'h48);
    wr(3'd0, {8'h00, 8'(op)});
    wr(3'd0, {lba[23:16], lba[31:24]});
    wr(3'd0, {lba[7:0], lba[15:8]});
    wr(3'd0, {8'(cnt >> 8), 8'h00});
    wr(3'd0, {8'h00, 8'(cnt)});
    wr(3'd0, 16'h0000);
    rd(3'd7, s); chk("R10 BSY after packet", s, 'hC0);
    if (op != 'h28) begin
      wait_irq("R12 irq on bad opcode");
      rd(3'd7, s); chk("R12 status on bad opcode", s, 'h41);
      rd(3'd1, s); chk("R12 abort bit", s, 'h04);
      return;
    end
    if (cnt == 0) begin
      wait_irq("R13 irq on zero count");
      rd(3'd7, s); chk("R13 status on zero count", s, 'h40);
      return;
    end
    total = cnt * 2048;
    k = 0;
    while (total > 0) begin
      wait_irq("R7 irq before burst");
      rd(3'd7, s); chk("R7 status before burst", s, 'h48);
      @(negedge clk); #3 chk("R9 irq cleared by status read", int'(intrq), 0);
      b = (total < (lim & 'hFFFE)) ? total : (lim & 'hFFFE);
      rd(3'd4, lo); rd(3'd5, hi);
      chk("R6 burst byte count", (hi << 8) | lo, b);
      for (int i = 0; i < b / 2; i++) begin
        rd(3'd0, s);
        chk("R5 data word", s, int'(mfn(lba + 32'(k / WPB), k % WPB)));
        k++;
      end
      total -= b;
      if (total > 0) begin
        rd(3'd7, s); chk("R10 BSY between bursts", s, 'hC0);
      end
    end
    wait_irq("R8 final irq");
    rd(3'd7, s); chk("R8 final status", s, 'h40);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R8 watchdog act=hung exp=complete");
    summary();
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    rd(3'd7, s); chk("R1 reset status", s, 'h40);
    rd(3'd1, s); chk("R1 reset error", s, 0);
    rd(3'd4, s); chk("R1 reset cap", s, 0);
    chk("R1 reset intrq", int'(intrq), 0);
    wr(3'd4, 16'h0034); wr(3'd5, 16'h0012);
    rd(3'd4, s); chk("R3 cap low", s, 'h34);
    rd(3'd5, s); chk("R3 cap high", s, 'h12);

    packet(5120, 'h28, 32'h0, 1);
    packet(5120, 'h28, 32'h01020304, 6);
    packet(1001, 'h28, 32'h7, 1);

    wr(3'd4, 16'h0); wr(3'd5, 16'h0); wr(3'd7, 16'h00A0);
    @(negedge clk); #3 chk("R11 irq on zero cap", int'(intrq), 1);
    rd(3'd7, s); chk("R11 status on zero cap", s, 'h41);
    rd(3'd1, s); chk("R11 abort on zero cap", s, 'h04);
    wr(3'd4, 16'h1); wr(3'd7, 16'h00A0);
    rd(3'd7, s); chk("R11 status on cap of one", s, 'h41);

    wr(3'd4, 16'h00); wr(3'd5, 16'h08); wr(3'd7, 16'h00EC);
    rd(3'd7, s); chk("R11 status on foreign command", s, 'h41);
    rd(3'd1, s); chk("R11 abort on foreign command", s, 'h04);

    packet(2048, 'h12, 32'h0, 1);
    packet(2048, 'h28, 32'h5, 0);
    packet(4096, 'h28, 32'h3FF, 2);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule